// File: doc/BRIEF.md
# Address-Match Breakpoint Unit

This block watches the processor's bus address and requests entry into debug mode when the address equals any of four programmable 24-bit breakpoint addresses. Each breakpoint has its own enable. The address it compares depends on the processor's addressing mode. In full 24-bit mode the bus address is used as it is. In 16-bit compatibility mode, an 8-bit memory base value supplies the top byte and the bus supplies the low 16 bits.

A match during the first opcode fetch of an instruction requests the break at once. A match on any other bus cycle, such as an operand or data access, is held as pending. It is then released when the processor signals that the current instruction has ended. A debug controller loads the breakpoint addresses and enables through a small byte-wide write port. Several breakpoints can be armed together, for example to catch both targets of a branch.

Top module: `brkpt_match_unit`

## Requirements
- R1: A write with `cfg_idx` 0 to 3 selects breakpoint set 0 to 3. `cfg_bsel` 0 writes address bits 7:0, 1 writes bits 15:8 and 2 writes bits 23:16. A write with `cfg_bsel` 3 to an address set changes nothing.
- R2: A write with `cfg_idx` 4 loads `cfg_wdata[3:0]` as the enables, with bit i enabling set i. All enables are 0 after reset. A newly written enable first applies to the bus cycle after the write cycle.
- R3: When `mode24` is 1, the compared address is `bus_addr[23:0]`.
- R4: When `mode24` is 0, the compared address is `{mem_base, bus_addr[15:0]}`, and `bus_addr[23:16]` is ignored.
- R5: A cycle with `bus_valid` at 0 never causes a break and never sets the pending flag.
- R6: An enabled match with `bus_opfetch` at 1 drives `brk_req` high in the following cycle.
- R7: An enabled match with `bus_opfetch` at 0 sets `brk_pend` in the following cycle without raising `brk_req`. `brk_req` is then driven high in the cycle after `instr_end` is seen, and `brk_pend` clears in that same cycle.
- R8: `brk_req` is high for one cycle at most, and never for two cycles in a row.
- R9: While `in_debug` is 1, matches are ignored, no break is issued, and `brk_pend` is cleared in the following cycle.
- R10: The four sets compare independently. An enabled match on any set causes a break, and a match on a disabled set does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 3 | Register index: 0-3 address sets, 4 enables |
| cfg_bsel | input | 2 | Byte select within an address set |
| cfg_wdata | input | 8 | Write data byte |
| bus_addr | input | 24 | Processor bus address |
| bus_valid | input | 1 | Bus cycle qualifier |
| bus_opfetch | input | 1 | Cycle is the first opcode fetch of an instruction |
| mode24 | input | 1 | 1: full 24-bit addressing, 0: 16-bit compatibility |
| mem_base | input | 8 | Upper address byte used in compatibility mode |
| instr_end | input | 1 | Pulse marking the last cycle of an instruction |
| in_debug | input | 1 | Processor is already in debug mode |
| brk_req | output | 1 | Registered single-cycle break request |
| brk_pend | output | 1 | A deferred break is waiting for instruction end |

## Verification
All results come from registers, so each one appears one clock after the cycle that causes it. An opcode-fetch match shows on `brk_req` one cycle later. A deferred match shows on `brk_pend` one cycle later, and the release shows on `brk_req` one cycle after `instr_end`. An enable takes effect for the bus cycle after its write. The bench drives each stimulus for exactly one cycle on a falling edge and samples at the next falling edge, which falls just after the capturing rising edge. Where the expected result is silence, it keeps sampling for further cycles to confirm that nothing late appears.

// File: rtl/brkpt_match_unit.sv
module brkpt_match_unit #(
  parameter int NSETS = 4,
  parameter int AW    = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_idx,
  input  logic [1:0]    cfg_bsel,
  input  logic [7:0]    cfg_wdata,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_valid,
  input  logic          bus_opfetch,
  input  logic          mode24,
  input  logic [7:0]    mem_base,
  input  logic          instr_end,
  input  logic          in_debug,
  output logic          brk_req,
  output logic          brk_pend
);
  localparam int ENIDX = NSETS;

  logic [AW-1:0]    bp_addr [NSETS];
  logic [NSETS-1:0] en_q;
  logic [NSETS-1:0] hit;
  logic [AW-1:0]    eff_addr;
  logic             any_hit, fire, take, def_hit;

  assign eff_addr = mode24 ? bus_addr : {mem_base, bus_addr[15:0]};

  for (genvar i = 0; i < NSETS; i++) begin : g_set
    always_ff @(posedge clk) begin
      if (cfg_we && cfg_idx == 3'(i)) begin
        case (cfg_bsel)
          2'd0: bp_addr[i][7:0]   <= cfg_wdata;
          2'd1: bp_addr[i][15:8]  <= cfg_wdata;
          2'd2: bp_addr[i][23:16] <= cfg_wdata;
          default: ;
        endcase
      end
    end
    assign hit[i] = en_q[i] && (eff_addr == bp_addr[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               en_q <= '0;
    else if (cfg_we && cfg_idx == 3'(ENIDX))  en_q <= cfg_wdata[NSETS-1:0];
  end

  assign any_hit = bus_valid && !in_debug && (|hit);
  assign def_hit = any_hit && !bus_opfetch;
  assign fire    = !in_debug && ((any_hit && bus_opfetch) ||
                                 (instr_end && (brk_pend || def_hit)));
  assign take    = fire && !brk_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_req  <= 1'b0;
      brk_pend <= 1'b0;
    end else begin
      brk_req <= take;
      if (in_debug || take) brk_pend <= 1'b0;
      else if (def_hit)     brk_pend <= 1'b1;
    end
  end
endmodule

module brkpt_match_chk #(
  parameter int NSETS = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_debug,
  input logic             instr_end,
  input logic             bus_valid,
  input logic             brk_req,
  input logic             brk_pend,
  input logic [NSETS-1:0] en_q
);
  p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |=> !brk_req);
  p_quiet_debug_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_debug |=> (!brk_req && !brk_pend));
  p_no_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0 && !brk_pend) |=> !brk_req);
  p_invalid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_valid && !brk_pend) |=> !brk_pend);
  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_pend && instr_end && !in_debug && !brk_req) |=> (brk_req && !brk_pend));
endmodule

bind brkpt_match_unit brkpt_match_chk #(.NSETS(NSETS)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_debug(in_debug), .instr_end(instr_end),
  .bus_valid(bus_valid), .brk_req(brk_req), .brk_pend(brk_pend), .en_q(en_q)
);

// File: tb/tb_brkpt_match_unit.sv
module tb_brkpt_match_unit;
  logic        clk = 0, rst_n = 0;
  logic        cfg_we = 0;
  logic [2:0]  cfg_idx = 0;
  logic [1:0]  cfg_bsel = 0;
  logic [7:0]  cfg_wdata = 0;
  logic [23:0] bus_addr = 0;
  logic        bus_valid = 0, bus_opfetch = 0, mode24 = 1;
  logic [7:0]  mem_base = 0;
  logic        instr_end = 0, in_debug = 0;
  logic        brk_req, brk_pend;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  brkpt_match_unit dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_bsel(cfg_bsel), .cfg_wdata(cfg_wdata), .bus_addr(bus_addr),
    .bus_valid(bus_valid), .bus_opfetch(bus_opfetch), .mode24(mode24),
    .mem_base(mem_base), .instr_end(instr_end), .in_debug(in_debug),
    .brk_req(brk_req), .brk_pend(brk_pend)
  );

  task automatic chk(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] idx, logic [1:0] bs, logic [7:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_idx = idx; cfg_bsel = bs; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic set_bp(int i, logic [23:0] a);
    wr(3'(i), 2'd0, a[7:0]);
    wr(3'(i), 2'd1, a[15:8]);
    wr(3'(i), 2'd2, a[23:16]);
  endtask

  task automatic bus(logic [23:0] a, logic v, logic f, logic ie);
    @(negedge clk);
    bus_addr = a; bus_valid = v; bus_opfetch = f; instr_end = ie;
    @(negedge clk);
    bus_valid = 0; bus_opfetch = 0; instr_end = 0;
  endtask

  task automatic t_reset;
    chk("R2 reset brk_req", brk_req, 0);
    chk("R2 reset brk_pend", brk_pend, 0);
  endtask

  task automatic t_fetch24;
    mode24 = 1;
    set_bp(0, 24'h123456);
    bus(24'h123456, 1, 1, 0);
    chk("R2 disabled set silent", brk_req, 0);
    wr(3'd4, 0, 8'h01);
    bus(24'h123456, 1, 1, 0);
    chk("R6 R3 fetch match", brk_req, 1);
    @(negedge clk);
    chk("R8 single pulse", brk_req, 0);
    bus(24'h123457, 1, 1, 0);
    chk("R3 mismatch low bit", brk_req, 0);
    bus(24'h133456, 1, 1, 0);
    chk("R3 mismatch upper byte", brk_req, 0);
  endtask

  task automatic t_enable_timing;
    wr(3'd4, 0, 8'h00);
    @(negedge clk);
    cfg_we = 1; cfg_idx = 3'd4; cfg_wdata = 8'h01;
    bus_addr = 24'h123456; bus_valid = 1; bus_opfetch = 1;
    @(negedge clk);
    cfg_we = 0; bus_valid = 0; bus_opfetch = 0;
    chk("R2 enable not same cycle", brk_req, 0);
    bus(24'h123456, 1, 1, 0);
    chk("R2 enable next cycle", brk_req, 1);
  endtask

  task automatic t_mode16;
    mode24 = 0; mem_base = 8'h12;
    bus(24'hFF3456, 1, 1, 0);
    chk("R4 base joined, upper ignored", brk_req, 1);
    mem_base = 8'h00;
    bus(24'h123456, 1, 1, 0);
    chk("R4 bus upper not used", brk_req, 0);
    mode24 = 1;
  endtask

  task automatic t_valid;
    bus(24'h123456, 0, 1, 0);
    chk("R5 invalid no brk", brk_req, 0);
    bus(24'h123456, 0, 0, 0);
    chk("R5 invalid no pend", brk_pend, 0);
  endtask

  task automatic t_deferred;
    bus(24'h123456, 1, 0, 0);
    chk("R7 no immediate brk", brk_req, 0);
    chk("R7 pend set", brk_pend, 1);
    bus(24'h000000, 1, 1, 0);
    chk("R7 still waiting", brk_req, 0);
    chk("R7 pend held", brk_pend, 1);
    bus(24'h000000, 0, 0, 1);
    chk("R7 release at end", brk_req, 1);
    chk("R7 pend cleared", brk_pend, 0);
    @(negedge clk);
    chk("R8 deferred pulse ends", brk_req, 0);
  endtask

  task automatic t_debug;
    in_debug = 1;
    bus(24'h123456, 1, 1, 0);
    chk("R9 ignored in debug", brk_req, 0);
    in_debug = 0;
    bus(24'h123456, 1, 0, 0);
    chk("R9 pend before debug", brk_pend, 1);
    in_debug = 1;
    bus(24'h000000, 0, 0, 1);
    chk("R9 pend cleared", brk_pend, 0);
    chk("R9 no brk at end", brk_req, 0);
    in_debug = 0;
    @(negedge clk);
    chk("R9 nothing later", brk_req, 0);
  endtask

  task automatic t_multi;
    set_bp(2, 24'hABCDEF);
    set_bp(3, 24'h00F00D);
    wr(3'd1, 2'd0, 8'h11);
    wr(3'd1, 2'd1, 8'h22);
    wr(3'd1, 2'd2, 8'h33);
    wr(3'd1, 2'd3, 8'h99);
    wr(3'd4, 0, 8'h0E);
    bus(24'hABCDEF, 1, 1, 0);
    chk("R10 set2 hit", brk_req, 1);
    bus(24'h00F00D, 1, 1, 0);
    chk("R10 set3 hit", brk_req, 1);
    bus(24'h332211, 1, 1, 0);
    chk("R1 bsel3 ignored", brk_req, 1);
    bus(24'h123456, 1, 1, 0);
    chk("R10 disabled set0 silent", brk_req, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_fetch24();
    t_enable_timing();
    t_mode16();
    t_valid();
    t_deferred();
    t_debug();
    t_multi();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=running expected=finished");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule